// File: doc/BRIEF.md
# Multi-Channel Pulse-Width Modulator with Synchronised Enable Commit

A bank of independent pulse-width modulation channels. Each channel counts clock ticks from zero up to a programmed limit and then wraps. Its output is high while the count is below a programmed high time, and the last tick of every cycle is always low. A one-cycle end-of-cycle strobe marks the wrap. Software programs the limit and the high time of each channel through a plain write/read register port. The bank copies these values into the working registers of a channel only when that channel wraps, so a running waveform never changes part way through a cycle.

Enable bits follow a separate path. A write to the enable register only stages the new bits. They reach the channels when software writes a one to the update register, and that register clears itself. All channels that this write switches on start counting from zero in the same tick, so they stay in phase. A channel switched off in this way first finishes the cycle it is in and then stays low.

Top module: `pwm_bank`

## Requirements
- R1: After reset every PWM output and every end-of-cycle strobe is low, and reads of the enable, limit and high-time registers return 0.
- R2: A limit value x gives a cycle of x+1 ticks. The end-of-cycle strobe is high for exactly the last tick of each cycle.
- R3: In each cycle the output is high for the first min(high time, limit) ticks and low for the rest. The last tick is therefore always low, even when the high time is larger than the limit.
- R4: With a limit of 0 an enabled channel keeps its output low and raises the end-of-cycle strobe on every tick.
- R5: A write to the enable register (address 0, bit i for channel i) changes no output until the update register is written. A read of address 0 returns the staged bits.
- R6: Writing 1 to bit 0 of the update register (address 1) starts every channel that is staged on and idle, with the count at 0 in the next tick. Channels started by the same update run in phase.
- R7: When an update commits an enable bit of 0 to a running channel, the channel finishes its current cycle and then holds its output and its strobe low.
- R8: A new limit (address 2+2i) or high time (address 3+2i) for channel i does not change the current cycle. It takes effect from the cycle after the next end-of-cycle strobe of that channel, and no update write is needed.
- R9: A reload or a commit on one channel does not change the waveform of any other channel.
- R10: The update register reads 0. Limit and high-time reads return the last value written, even before the channel has loaded it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; each cycle is one PWM tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| we | input | 1 | Register write strobe |
| addr | input | AW | Register address for writes and reads |
| wdata | input | CW | Write data |
| rdata | output | CW | Read data for `addr`, combinational |
| pwm_o | output | NCH | PWM output, one bit per channel |
| eop_o | output | NCH | End-of-cycle strobe, one bit per channel |

## Verification
The main waveform is driven with several limit and high-time pairs: a short cycle with a high time inside it, a high time larger than the limit, and a limit of zero. Together they separate the x+1 cycle length, the forced low last tick and the degenerate constant-low case. Two channels are started by one update to show that their phases match, while an already running channel must not move. A reload is written in the middle of a cycle and a disable is committed in the middle of a cycle, so that an immediate effect can be told apart from an effect deferred to the end of the cycle. A bench-side model of every channel compares both outputs on every tick.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  // register address map
  localparam int unsigned A_EN  = 0;  // staged enable bits, bit i = channel i
  localparam int unsigned A_UPD = 1;  // write 1 to bit 0 to commit enables
  localparam int unsigned A_CH0 = 2;  // channel i: limit at A_CH0+2i, high time at A_CH0+2i+1
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_bank_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = 32,
  parameter int AW  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [AW-1:0]           addr,
  input  logic [CW-1:0]           wdata,
  output logic [CW-1:0]           rdata,
  output logic [NCH-1:0][CW-1:0]  cfg_rng,
  output logic [NCH-1:0][CW-1:0]  cfg_dty,
  output logic [NCH-1:0]          en_stage,
  output logic                    upd_pulse
);
  logic [NCH-1:0][CW-1:0] rng_q, rng_nx, dty_q, dty_nx;
  logic [NCH-1:0]         en_q, en_nx;

  // next-state
  always_comb begin
    rng_nx = rng_q;
    dty_nx = dty_q;
    en_nx  = en_q;
    if (we && addr == AW'(A_EN)) en_nx = wdata[NCH-1:0];
    for (int i = 0; i < NCH; i++) begin
      if (we && addr == AW'(A_CH0 + 2*i))     rng_nx[i] = wdata;
      if (we && addr == AW'(A_CH0 + 2*i + 1)) dty_nx[i] = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rng_q <= '0;
      dty_q <= '0;
      en_q  <= '0;
    end else if (we) begin
      rng_q <= rng_nx;
      dty_q <= dty_nx;
      en_q  <= en_nx;
    end
  end

  // commit strobe is never stored, so it clears itself
  assign upd_pulse = we && (addr == AW'(A_UPD)) && wdata[0];

  always_comb begin
    rdata = '0;
    if (addr == AW'(A_EN)) rdata[NCH-1:0] = en_q;
    for (int i = 0; i < NCH; i++) begin
      if (addr == AW'(A_CH0 + 2*i))     rdata = rng_q[i];
      if (addr == AW'(A_CH0 + 2*i + 1)) rdata = dty_q[i];
    end
  end

  assign cfg_rng  = rng_q;
  assign cfg_dty  = dty_q;
  assign en_stage = en_q;

  p_upd_needs_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    upd_pulse |-> (we && rdata == '0));
endmodule

// File: rtl/pwm_lane.sv
module pwm_lane #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cfg_rng,
  input  logic [CW-1:0] cfg_dty,
  input  logic          en_stage,
  input  logic          upd,
  output logic          pwm_o,
  output logic          eop_o
);
  logic          run_q, run_nx;
  logic          en_q, en_nx;
  logic [CW-1:0] cnt_q, cnt_nx;
  logic [CW-1:0] rng_q, dty_q;
  logic          at_end, start, ld;

  assign at_end = run_q && (cnt_q == rng_q);
  assign start  = upd && en_stage && !run_q;
  assign ld     = at_end || start;

  // next-state
  always_comb begin
    en_nx  = upd ? en_stage : en_q;
    run_nx = run_q;
    cnt_nx = cnt_q;
    if (run_q) begin
      if (at_end) begin
        cnt_nx = '0;
        run_nx = en_nx;
      end else begin
        cnt_nx = cnt_q + 1'b1;
      end
    end else if (start) begin
      run_nx = 1'b1;
      cnt_nx = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      en_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run_nx;
      en_q  <= en_nx;
      cnt_q <= cnt_nx;
    end
  end

  // working copies load only at a wrap or a start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rng_q <= '0;
      dty_q <= '0;
    end else if (ld) begin
      rng_q <= cfg_rng;
      dty_q <= cfg_dty;
    end
  end

  assign pwm_o = run_q && (cnt_q < dty_q) && (cnt_q < rng_q);
  assign eop_o = at_end;

  p_last_tick_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    eop_o |-> !pwm_o);
  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !eop_o) |=> (cnt_q == $past(cnt_q) + 1'b1));
  p_wrap_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (eop_o && en_q && !upd) |=> (run_q && cnt_q == '0));
  p_hold_working_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !eop_o) |=> ($stable(rng_q) && $stable(dty_q)));
  p_stop_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (eop_o && !en_q && !upd) |=> (!pwm_o && !eop_o));
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank #(
  parameter int NCH = 4,
  parameter int CW  = 32,
  parameter int AW  = $clog2(2 + 2*NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [AW-1:0]  addr,
  input  logic [CW-1:0]  wdata,
  output logic [CW-1:0]  rdata,
  output logic [NCH-1:0] pwm_o,
  output logic [NCH-1:0] eop_o
);
  logic [NCH-1:0][CW-1:0] cfg_rng, cfg_dty;
  logic [NCH-1:0]         en_stage;
  logic                   upd_pulse;

  pwm_regs #(.NCH(NCH), .CW(CW), .AW(AW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (we),
    .addr     (addr),
    .wdata    (wdata),
    .rdata    (rdata),
    .cfg_rng  (cfg_rng),
    .cfg_dty  (cfg_dty),
    .en_stage (en_stage),
    .upd_pulse(upd_pulse)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_lane
    pwm_lane #(.CW(CW)) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .cfg_rng (cfg_rng[g]),
      .cfg_dty (cfg_dty[g]),
      .en_stage(en_stage[g]),
      .upd     (upd_pulse),
      .pwm_o   (pwm_o[g]),
      .eop_o   (eop_o[g])
    );
  end
endmodule

// File: tb/pwm_bank_bench.sv
module pwm_bank_bench;
  localparam int NCH = 4;
  localparam int CW  = 32;
  localparam int AW  = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           we = 1'b0;
  logic [AW-1:0]  addr = '0;
  logic [CW-1:0]  wdata = '0;
  logic [CW-1:0]  rdata;
  logic [NCH-1:0] pwm_o, eop_o;

  int n_chk = 0;
  int n_bad = 0;
  bit sb_on = 1'b0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  pwm_bank #(.NCH(NCH), .CW(CW), .AW(AW)) u_pwm_bank (
    .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pwm_o(pwm_o), .eop_o(eop_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d @%0t", req, act, exp, $time);
    end
  endtask

  // ---------------- bench model from the requirements ----------------
  logic [CW-1:0]  m_cr[NCH], m_cd[NCH], m_r[NCH], m_d[NCH], m_k[NCH];
  logic [NCH-1:0] m_stage, m_en, m_run;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stage = '0; m_en = '0; m_run = '0;
      for (int c = 0; c < NCH; c++) begin
        m_cr[c] = '0; m_cd[c] = '0; m_r[c] = '0; m_d[c] = '0; m_k[c] = '0;
      end
    end else begin
      bit upd;
      upd = we && addr == 1 && wdata[0];
      for (int c = 0; c < NCH; c++) begin
        bit ne;
        ne = upd ? m_stage[c] : m_en[c];
        if (m_run[c]) begin
          if (m_k[c] == m_r[c]) begin
            m_k[c] = '0; m_r[c] = m_cr[c]; m_d[c] = m_cd[c];
            if (!ne) m_run[c] = 1'b0;
          end else m_k[c] = m_k[c] + 1;
        end else if (upd && m_stage[c]) begin
          m_run[c] = 1'b1; m_k[c] = '0; m_r[c] = m_cr[c]; m_d[c] = m_cd[c];
        end
        m_en[c] = ne;
      end
      if (we) begin
        if (addr == 0) m_stage = wdata[NCH-1:0];
        for (int c = 0; c < NCH; c++) begin
          if (addr == AW'(2 + 2*c)) m_cr[c] = wdata;
          if (addr == AW'(3 + 2*c)) m_cd[c] = wdata;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (sb_on && !done) begin
      for (int c = 0; c < NCH; c++) begin
        bit eo, ee;
        eo = m_run[c] && (m_k[c] < m_d[c]) && (m_k[c] < m_r[c]);
        ee = m_run[c] && (m_k[c] == m_r[c]);
        chk(pwm_o[c] == eo, "R3 R6 R9 pwm tick", pwm_o[c], eo);
        chk(eop_o[c] == ee, "R2 R7 R9 eop tick", eop_o[c], ee);
      end
    end
  end

  // ---------------- access helpers ----------------
  task automatic wr(input int a, input logic [CW-1:0] d);
    @(negedge clk);
    we = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [CW-1:0] d);
    @(negedge clk);
    addr = AW'(a);
    #1 d = rdata;
  endtask

  task automatic wait_eop(input int c);
    for (int i = 0; i < 100; i++) begin
      if (eop_o[c]) return;
      @(negedge clk);
    end
  endtask

  task automatic gap(input int c, output int g);
    wait_eop(c);
    g = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      g++;
      if (eop_o[c]) return;
    end
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    logic [CW-1:0] v;
    chk(pwm_o == '0, "R1 pwm after reset", pwm_o, 0);
    chk(eop_o == '0, "R1 eop after reset", eop_o, 0);
    rd(0, v); chk(v == 0, "R1 enable read", v, 0);
    rd(2, v); chk(v == 0, "R1 limit read", v, 0);
    rd(3, v); chk(v == 0, "R1 high-time read", v, 0);
  endtask

  task automatic t_staged();
    logic [CW-1:0] v;
    wr(2, 4); wr(3, 2);
    wr(4, 4); wr(5, 2);
    wr(0, 32'h1);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(pwm_o == '0 && eop_o == '0, "R5 no effect before update", {pwm_o, eop_o}, 0);
    end
    rd(0, v); chk(v == 1, "R5 staged read", v, 1);
  endtask

  task automatic t_start();
    int highs;
    wr(0, 32'h3);
    wr(1, 1);
    highs = 0;
    for (int k = 0; k < 10; k++) begin
      chk(pwm_o[0] == pwm_o[1] && eop_o[0] == eop_o[1], "R6 in phase", pwm_o[1:0], {2{pwm_o[0]}});
      chk(eop_o[0] == ((k % 5) == 4), "R2 eop position", eop_o[0], (k % 5) == 4);
      if (pwm_o[0]) highs++;
      @(negedge clk);
    end
    chk(highs == 4, "R3 high ticks in two cycles", highs, 4);
  endtask

  task automatic t_full_duty();
    int highs;
    wr(6, 3); wr(7, 9);
    wr(0, 32'h7);
    wr(1, 1);
    highs = 0;
    for (int k = 0; k < 8; k++) begin
      if (pwm_o[2]) highs++;
      if (eop_o[2]) chk(!pwm_o[2], "R3 last tick low", pwm_o[2], 0);
      @(negedge clk);
    end
    chk(highs == 6, "R3 high time capped by limit", highs, 6);
  endtask

  task automatic t_range_zero();
    wr(8, 0); wr(9, 5);
    wr(0, 32'hF);
    wr(1, 1);
    for (int k = 0; k < 8; k++) begin
      chk(!pwm_o[3], "R4 constant low", pwm_o[3], 0);
      chk(eop_o[3], "R4 strobe every tick", eop_o[3], 1);
      @(negedge clk);
    end
  endtask

  task automatic t_reload();
    logic [CW-1:0] v;
    int g;
    wait_eop(0);
    @(negedge clk); @(negedge clk);
    wr(2, 6); wr(3, 3);
    rd(2, v); chk(v == 6, "R10 limit readback", v, 6);
    rd(1, v); chk(v == 0, "R10 update reads zero", v, 0);
    gap(0, g); chk(g == 7, "R8 new limit after wrap", g, 7);
    gap(1, g); chk(g == 5, "R9 neighbour period kept", g, 5);
  endtask

  task automatic t_disable();
    int ne;
    wait_eop(0);
    @(negedge clk); @(negedge clk);
    wr(0, 32'hE);
    wr(1, 1);
    ne = 0;
    for (int k = 0; k < 10; k++) begin
      if (eop_o[0]) ne++;
      @(negedge clk);
    end
    chk(ne == 1, "R7 finishes current cycle", ne, 1);
    for (int k = 0; k < 20; k++) begin
      chk(!pwm_o[0] && !eop_o[0], "R7 stays low", {pwm_o[0], eop_o[0]}, 0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    sb_on = 1'b1;
    t_staged();
    t_start();
    t_full_duty();
    t_range_zero();
    t_reload();
    t_disable();
    sb_on = 1'b0;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule